// File: doc/BRIEF.md
# Configurable Pixel Channel Unpacker

This block turns a stream of 64-bit frame-memory words into a stream of pixels with 8-bit red, green and blue values. A word is split into pixels of one to four bytes. The byte order inside each pixel is selectable. Each colour channel is then cut out of the pixel with its own bit offset, bit width and default value. It sits between a line FIFO and the display timing logic: the FIFO offers words, and the timing logic pulls one pixel at a time.

Both streams use a valid/ready handshake. An input word is taken on a clock edge where `in_valid` and `in_ready` are both high. At that same edge the format word, the three channel selectors and the red/blue swap flag are captured along with the data. Changing them afterwards does not affect the pixels of that word. The format can therefore change at any word boundary, for example from one frame to the next.

A pixel is delivered on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output holds steady. `in_ready` is high only when no word is held, or when the last pixel of the held word leaves in that cycle. With a continuous supply of words and a sink that is always ready, one pixel leaves every cycle with no gaps between words.

Top module: `chan_unpack`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `out_valid` is high exactly while pixels of an accepted word remain. While `out_valid` is high and `out_ready` is low, `out_r`, `out_g` and `out_b` hold their values. `in_ready` is high only when no pixels remain, or when exactly one remains and `out_ready` is high. One pixel leaves per cycle when the sink is ready.
- R3: The byte-count field `pix_fmt[4:3]` = n gives pixels of n+1 bytes. A word yields 8 div (n+1) pixels, which is 8, 4, 2 or 2. Pixels are taken from the lowest byte address first, where byte address a is `in_data[8a+7:8a]`. Leftover bytes are dropped.
- R4: With `pix_fmt[31]` = 0 the byte at the lowest address of a pixel is its least significant byte. With `pix_fmt[31]` = 1 it is the most significant byte.
- R5: A channel selector has the bit offset in bits [4:0], the width in bits [11:8] and the default value in bits [23:16]. The field value is (pixel >> offset) modulo 2^w, where pixel bits above the pixel size read as 0. Widths 8 to 15 act as w = 8, and the output is then the field itself. Byte-order conversion is applied before the field is extracted.
- R6: A channel whose width is 0 outputs its default value.
- R7: A field of width 1 to 7 is placed in the top bits of the 8-bit output. Its bits are then repeated, most significant first, to fill the lower bits.
- R8: With `swap_rb` = 1, the red channel's result appears on `out_b` and the blue channel's result appears on `out_r`.
- R9: The format, selectors and swap flag are captured when a word is accepted. Changes while that word's pixels drain have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken |
| in_data | input | 64 | Packed pixel bytes, byte address 0 in bits 7:0 |
| pix_fmt | input | 32 | Byte count code in [4:3], big-endian flag in [31] |
| sel_red | input | 24 | Red selector: offset [4:0], width [11:8], default [23:16] |
| sel_grn | input | 24 | Green selector, same layout |
| sel_blu | input | 24 | Blue selector, same layout |
| swap_rb | input | 1 | Exchange red and blue outputs |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Sink takes the pixel |
| out_r | output | 8 | Red value |
| out_g | output | 8 | Green value |
| out_b | output | 8 | Blue value |

## Verification
The assertions assume that the sink obeys the handshake only as far as the design's own state requires. They also assume that reset is held for at least one edge before any traffic, so that the captured configuration is defined whenever the channel checks run. The stimulus holds `in_data` and the configuration steady while a word is offered. It changes them only at a falling edge after the word is taken, so every capture sees one consistent set of values. The bench sweeps every byte-count code in both byte orders. It covers widths 0, 1 to 7 and 8 to 15 at offsets up to 31, random back-pressure and input gaps, and a configuration that changes on every word.

// File: rtl/chan_unpack_pkg.sv
package chan_unpack_pkg;
  localparam int CH_W  = 8;
  localparam int OFF_W = 5;
  localparam int WID_W = 4;

  typedef struct packed {
    logic [CH_W-1:0]  dflt;
    logic [WID_W-1:0] width;
    logic [OFF_W-1:0] off;
  } chan_cfg_t;
endpackage

// File: rtl/pix_pick.sv
module pix_pick #(
  parameter int WORD_BYTES = 8,
  parameter int PIX_MAX    = 4,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int PIX_W     = 8 * PIX_MAX,
  localparam int IDX_W     = $clog2(WORD_BYTES)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        code,
  input  logic              big_end,
  input  logic [IDX_W-1:0]  idx,
  output logic [PIX_W-1:0]  pix
);
  logic [2:0]       nbytes;
  logic [7:0]       start;
  logic [7:0]       bi;
  logic [WORD_W-1:0] shifted;
  logic [7:0]       byt;
  int unsigned      sh;

  always_comb begin
    nbytes = {1'b0, code} + 3'd1;
    start  = 8'(idx) * 8'(nbytes);
    pix    = '0;
    bi     = '0;
    shifted = '0;
    byt    = '0;
    sh     = 0;
    for (int k = 0; k < PIX_MAX; k++) begin
      if (k < int'(nbytes)) begin
        bi      = start + 8'(k);
        shifted = word >> {bi, 3'b000};
        byt     = shifted[7:0];
        sh      = big_end ? 8 * (int'(nbytes) - 1 - k) : 8 * k;
        pix     = pix | (PIX_W'(byt) << sh);
      end
    end
  end
endmodule

// File: rtl/chan_field.sv
module chan_field
  import chan_unpack_pkg::*;
#(
  parameter int PIX_MAX = 4,
  localparam int PIX_W  = 8 * PIX_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix,
  input  chan_cfg_t        cfg,
  output logic [CH_W-1:0]  ch
);
  logic [CH_W-1:0]  sh8;
  logic [WID_W-1:0] w;
  logic [CH_W-1:0]  raw;

  always_comb begin
    sh8 = CH_W'(pix >> cfg.off);
    w   = (cfg.width > WID_W'(CH_W)) ? WID_W'(CH_W) : cfg.width;
    raw = sh8 & (8'hFF >> (WID_W'(CH_W) - w));
    ch  = cfg.dflt;
    for (int wd = 1; wd <= CH_W; wd++) begin
      if (int'(w) == wd) begin
        for (int i = 0; i < CH_W; i++)
          ch[CH_W-1-i] = raw[wd-1-(i % wd)];
      end
    end
  end

  assert_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.width == '0) |-> (ch == cfg.dflt));

  assert_full_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.width >= WID_W'(CH_W)) |-> (ch == CH_W'(pix >> cfg.off)));
endmodule

// File: rtl/chan_unpack.sv
module chan_unpack
  import chan_unpack_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int PIX_MAX    = 4,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int IDX_W     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [31:0]       pix_fmt,
  input  logic [23:0]       sel_red,
  input  logic [23:0]       sel_grn,
  input  logic [23:0]       sel_blu,
  input  logic              swap_rb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_r,
  output logic [CH_W-1:0]   out_g,
  output logic [CH_W-1:0]   out_b
);
  localparam int NCH = 3;

  function automatic logic [IDX_W:0] pix_per_word(input logic [1:0] c);
    int n;
    n = WORD_BYTES / (int'(c) + 1);
    return (IDX_W+1)'(n);
  endfunction

  function automatic chan_cfg_t decode_sel(input logic [23:0] s);
    chan_cfg_t r;
    r.dflt  = s[23:16];
    r.width = s[11:8];
    r.off   = s[4:0];
    return r;
  endfunction

  logic unused_bits;
  assign unused_bits = ^{pix_fmt[30:5], pix_fmt[2:0], sel_red[15:12], sel_red[7:5],
                         sel_grn[15:12], sel_grn[7:5], sel_blu[15:12], sel_blu[7:5]};

  logic [WORD_W-1:0] word_q;
  logic [1:0]        code_q;
  logic              be_q;
  logic              swap_q;
  chan_cfg_t         cfg_q [NCH];
  logic              full_q;
  logic [IDX_W-1:0]  idx_q;

  logic [IDX_W:0]    npix;
  logic              last;
  logic              take;
  logic              give;
  logic [8*PIX_MAX-1:0] pix;
  logic [CH_W-1:0]   chan [NCH];

  assign npix      = pix_per_word(code_q);
  assign last      = ({1'b0, idx_q} == npix - 1'b1);
  assign out_valid = full_q;
  assign in_ready  = !full_q || (out_ready && last);
  assign take      = in_valid && in_ready;
  assign give      = full_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      code_q <= '0;
      be_q   <= 1'b0;
      swap_q <= 1'b0;
      full_q <= 1'b0;
      idx_q  <= '0;
      for (int c = 0; c < NCH; c++) cfg_q[c] <= '0;
    end else if (take) begin
      word_q   <= in_data;
      code_q   <= pix_fmt[4:3];
      be_q     <= pix_fmt[31];
      swap_q   <= swap_rb;
      cfg_q[0] <= decode_sel(sel_red);
      cfg_q[1] <= decode_sel(sel_grn);
      cfg_q[2] <= decode_sel(sel_blu);
      full_q   <= 1'b1;
      idx_q    <= '0;
    end else if (give) begin
      if (last) full_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  pix_pick #(.WORD_BYTES(WORD_BYTES), .PIX_MAX(PIX_MAX)) u_pick (
    .word    (word_q),
    .code    (code_q),
    .big_end (be_q),
    .idx     (idx_q),
    .pix     (pix)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    chan_field #(.PIX_MAX(PIX_MAX)) u_field (
      .clk   (clk),
      .rst_n (rst_n),
      .pix   (pix),
      .cfg   (cfg_q[c]),
      .ch    (chan[c])
    );
  end

  assign out_r = swap_q ? chan[2] : chan[0];
  assign out_g = chan[1];
  assign out_b = swap_q ? chan[0] : chan[2];

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> ({1'b0, idx_q} < npix));

  assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_q |-> ((out_r == chan[2]) && (out_b == chan[0])));
endmodule

// File: tb/chan_unpack_test.sv
`timescale 1ns/1ps
module chan_unpack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [31:0] pix_fmt = '0;
  logic [23:0] sel_red = '0, sel_grn = '0, sel_blu = '0;
  logic        swap_rb = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_r, out_g, out_b;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] rs = 32'h1badc0de;
  logic [23:0] q[$];

  always #10 clk = ~clk;

  chan_unpack uut (.*);

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic logic [23:0] mk_sel(int off, int w, int dflt);
    return {8'(dflt), 4'h0, 4'(w), 3'b000, 5'(off)};
  endfunction

  function automatic logic [31:0] mk_fmt(int code, bit be);
    return {be, 26'd0, 2'(code), 3'd0};
  endfunction

  function automatic int ref_ch(longint unsigned pix, logic [23:0] s);
    int off, w, v, bits;
    longint unsigned total;
    off = int'(s[4:0]);
    w = int'(s[11:8]);
    if (w > 8) w = 8;
    if (w == 0) return int'(s[23:16]);
    v = int'((pix >> off) % (64'd1 << w));
    total = 0;
    bits = 0;
    while (bits < 8) begin
      total = (total << w) | longint'(v);
      bits += w;
    end
    return int'(total >> (bits - 8));
  endfunction

  function automatic logic [23:0] ref_pix(logic [63:0] wd, logic [31:0] fmt,
      logic [23:0] sr, logic [23:0] sg, logic [23:0] sb, bit sw, int p);
    int nb, r, g, b;
    longint unsigned pix, byt;
    nb = int'(fmt[4:3]) + 1;
    pix = 0;
    for (int k = 0; k < nb; k++) begin
      byt = (wd >> (8 * (p * nb + k))) & 64'hFF;
      if (fmt[31]) pix = pix * 256 + byt;
      else pix = pix + (byt << (8 * k));
    end
    r = ref_ch(pix, sr);
    g = ref_ch(pix, sg);
    b = ref_ch(pix, sb);
    if (sw) return {8'(b), 8'(g), 8'(r)};
    return {8'(r), 8'(g), 8'(b)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic new_cfg(int rmode);
    logic [31:0] a;
    a = rnd();
    if (rmode == 0) return;
    pix_fmt = mk_fmt(int'(a[1:0]), a[2]);
    if (rmode == 1) begin
      sel_red = mk_sel(int'(rnd() % 32), 8 + int'(rnd() % 8), int'(rnd() % 256));
      sel_grn = mk_sel(int'(rnd() % 32), 8 + int'(rnd() % 8), int'(rnd() % 256));
      sel_blu = mk_sel(int'(rnd() % 32), 8 + int'(rnd() % 8), int'(rnd() % 256));
    end else if (rmode == 2) begin
      sel_red = mk_sel(int'(rnd() % 32), 1 + int'(rnd() % 7), int'(rnd() % 256));
      sel_grn = mk_sel(int'(rnd() % 32), 1 + int'(rnd() % 7), int'(rnd() % 256));
      sel_blu = mk_sel(int'(rnd() % 32), 1 + int'(rnd() % 7), int'(rnd() % 256));
    end else begin
      sel_red = rnd()[23:0];
      sel_grn = rnd()[23:0];
      sel_blu = rnd()[23:0];
      swap_rb = a[3];
    end
  endtask

  task automatic run_words(string tag, int nwords, int rmode, int rdy_mode);
    int sent = 0;
    int guard = 0;
    bit acc = 0;
    bit pv = 0;
    logic [23:0] prev_out = '0;
    logic [23:0] e;
    bit exp_ov, exp_ir;
    in_valid = 1'b0;
    while ((sent < nwords || q.size() != 0 || in_valid) && guard < 20000) begin
      guard++;
      @(negedge clk);
      if (acc) begin in_valid = 1'b0; acc = 0; end
      if (pv) chk("R2 hold", {8'h0, out_r, out_g, out_b}, {8'h0, prev_out});
      out_ready = (rdy_mode == 0) ? 1'b1 : (rnd()[0] | rnd()[1]);
      if (!in_valid && sent < nwords && (rdy_mode == 0 || rnd()[4])) begin
        in_data = {rnd(), rnd()};
        new_cfg(rmode);
        in_valid = 1'b1;
        sent++;
      end
      #5;
      exp_ov = (q.size() != 0);
      exp_ir = (q.size() == 0) || (q.size() == 1 && out_ready);
      chk("R2 out_valid", 32'(out_valid), 32'(exp_ov));
      chk("R2 in_ready", 32'(in_ready), 32'(exp_ir));
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk({tag, " unexpected pixel"}, 32'(out_valid), 32'd0);
        end else begin
          e = q.pop_front();
          chk(tag, {8'h0, out_r, out_g, out_b}, {8'h0, e});
        end
      end
      pv = out_valid && !out_ready;
      prev_out = {out_r, out_g, out_b};
      if (in_valid && in_ready) begin
        for (int p = 0; p < 8 / (int'(pix_fmt[4:3]) + 1); p++)
          q.push_back(ref_pix(in_data, pix_fmt, sel_red, sel_grn, sel_blu, swap_rb, p));
        acc = 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    #5;
    chk("R1 idle out_valid", 32'(out_valid), 32'd0);

    // R3: every byte count, little-endian, byte-wide fields
    sel_red = mk_sel(0, 8, 0);
    sel_grn = mk_sel(8, 8, 0);
    sel_blu = mk_sel(16, 8, 0);
    for (int c = 0; c < 4; c++) begin
      pix_fmt = mk_fmt(c, 1'b0);
      run_words("R3", 10, 0, 0);
    end
    // R4: big-endian with back-pressure
    for (int c = 0; c < 4; c++) begin
      pix_fmt = mk_fmt(c, 1'b1);
      run_words("R4", 10, 0, 1);
    end
    // R5: random offsets, widths 8..15
    run_words("R5", 60, 1, 1);
    // R6: zero width gives defaults
    sel_red = mk_sel(3, 0, 8'h5a);
    sel_grn = mk_sel(9, 0, 8'hc3);
    sel_blu = mk_sel(30, 0, 8'h01);
    for (int c = 0; c < 4; c++) begin
      pix_fmt = mk_fmt(c, c[0]);
      run_words("R6", 4, 0, 1);
    end
    // R7: narrow fields, MSB replication
    run_words("R7", 60, 2, 1);
    // R8: red and blue exchanged
    swap_rb = 1'b1;
    sel_red = mk_sel(0, 5, 0);
    sel_grn = mk_sel(5, 6, 0);
    sel_blu = mk_sel(11, 5, 0);
    for (int c = 0; c < 4; c++) begin
      pix_fmt = mk_fmt(c, c[1]);
      run_words("R8", 8, 0, 0);
    end
    swap_rb = 1'b0;
    // R9: configuration changes every word while the previous one drains
    run_words("R9", 120, 3, 1);
    run_words("R9", 60, 3, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule